// File: doc/BRIEF.md
# SDRAM DQ Data Path with Latency Alignment

This block sits between a memory controller and the 32-bit data pins of an SDRAM. It turns read and write column commands into per-cycle data beats and drives the write data and the per-byte output enables. It lines returning read data up with the programmed CAS latency and applies the byte-mask pins with their two different latencies: writes are masked in the cycle the mask is seen, reads two cycles after it.

A read or write burst runs for the programmed burst length. A continuous page burst runs until something ends it. A burst-stop, a precharge or a command in the opposite direction ends a burst. Read beats that were already issued still drain out of the latency pipeline. A mode input makes every write a single beat while reads keep their programmed length.

All command, mask and mode inputs are taken as the values on the SDRAM pins in the current cycle. Write data and enables are driven combinationally in that same cycle. Read data is captured at the rising edge that ends its bus cycle and is presented one cycle later on `rd_valid_o` / `rd_data_o` / `rd_be_o`. Command legality and spacing belong to the controller.

Top module: `sdram_dq_path`

## Requirements
- R1: For a read command in cycle t with CAS latency CL (`cas_lat_i` 1, 2 or 3; the value 0 is taken as 1), the first `rd_valid_o` pulse occurs in cycle t+CL+1 and carries the `dq_in_i` value of cycle t+CL. Later beats follow on consecutive cycles.
- R2: `burst_code_i` values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. The value 7 gives a continuous burst that runs until it is terminated. The values 4 to 6 give a single beat.
- R3: A write command in cycle t drives the write beats in cycles t to t+BL-1. In each beat `dq_out_o` equals `wr_data_i` with masked lanes forced to zero. Outside write beats `dq_oe_o` is zero.
- R4: Byte lane n is bits 8n+7:8n. During a write beat, `dqm_i[n]` high clears `dq_oe_o[n]` in the same cycle (mask latency 0).
- R5: `dqm_i[n]` high in cycle c masks lane n of the read data on the bus in cycle c+2. The beat reported in cycle c+3 has `rd_be_o[n]` low and byte n of `rd_data_o` zero.
- R6: A burst-stop or precharge in cycle p cancels the read beat of cycle p and all later beats of that burst. Beats issued before p still drain, which leaves CL-1 data beats on the bus after cycle p.
- R7: A burst-stop, a precharge or a read command in cycle p ends a write burst, so no write beat is driven in cycle p or after it.
- R8: With `wr_single_i` high, every write is exactly one beat whatever the burst code, while reads keep the programmed length.
- R9: While reset is active and until the first command, `rd_valid_o`, `rd_be_o`, `rd_data_o` and `dq_oe_o` are all zero.
- R10: `dq_oe_o` stays zero on every cycle in which read data returns, including every cycle of a read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 2 | CAS latency in clocks (1..3) |
| burst_code_i | input | 3 | Burst length code |
| wr_single_i | input | 1 | Single-beat write mode |
| rd_cmd_i | input | 1 | Read column command this cycle |
| wr_cmd_i | input | 1 | Write column command this cycle |
| stop_cmd_i | input | 1 | Burst-stop command this cycle |
| pre_cmd_i | input | 1 | Precharge command this cycle |
| dqm_i | input | 4 | Per-byte mask pins |
| wr_data_i | input | 32 | Write data for the current cycle |
| dq_in_i | input | 32 | Data sampled from the DQ pins |
| dq_out_o | output | 32 | Data to the DQ pin drivers |
| dq_oe_o | output | 4 | Per-byte DQ driver enables |
| rd_valid_o | output | 1 | Read beat valid |
| rd_data_o | output | 32 | Read beat data, masked bytes zero |
| rd_be_o | output | 4 | Read beat byte valid flags |

## Verification
The assertions assume that the CAS latency and the burst code change only while no burst is in flight. They also assume that read and write commands never fall in the same cycle, and that a write is never issued while unmasked read data can still reach the bus, which is the condition the contention check relies on. The stimulus sets each mode field before a scenario starts, issues one command per scenario, and idles several cycles between scenarios so that every pipeline drains before the next command.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;

  localparam int unsigned BEAT_W = 4;

  typedef enum logic [2:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } bl_code_e;

  // codes 4..6 are reserved and fall back to one beat
  function automatic logic [BEAT_W-1:0] bl_beats(logic [2:0] code);
    case (code)
      BL_TWO:   bl_beats = BEAT_W'(2);
      BL_FOUR:  bl_beats = BEAT_W'(4);
      BL_EIGHT: bl_beats = BEAT_W'(8);
      default:  bl_beats = BEAT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             beat_o
);

  logic [CNT_W-1:0] rem_q;
  logic             cont_q;
  logic             busy;

  assign busy   = (rem_q != '0) || cont_q;
  assign beat_o = !term_i && (start_i || busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      cont_q <= 1'b0;
    end else if (term_i) begin
      rem_q  <= '0;
      cont_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= cont_i ? '0 : len_i - CNT_W'(1);
      cont_q <= cont_i;
    end else if (rem_q != '0) begin
      rem_q  <= rem_q - CNT_W'(1);
    end
  end

  // R6 and R7: a terminated burst stays idle until a new start
  p_term_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(term_i) && !start_i) |-> !beat_o);

endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LANES   = DATA_W / 8,
  parameter int unsigned MAX_CL  = 3,
  parameter int unsigned CL_W    = 2,
  parameter int unsigned DQM_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [CL_W-1:0]   cas_lat_i,
  input  logic [LANES-1:0]  dqm_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [LANES-1:0]  live_lanes_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LANES-1:0]  rd_be_o
);

  logic [MAX_CL-1:0]               pipe_q;
  logic [DQM_LAT-1:0][LANES-1:0]   dqm_q;
  logic [LANES-1:0]                dqm_dly;
  logic                            on_bus;
  logic [DATA_W-1:0]               masked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      dqm_q  <= '0;
    end else begin
      pipe_q[0] <= beat_i;
      for (int i = 1; i < MAX_CL; i++) pipe_q[i] <= pipe_q[i-1];
      dqm_q[0] <= dqm_i;
      for (int i = 1; i < DQM_LAT; i++) dqm_q[i] <= dqm_q[i-1];
    end
  end

  assign dqm_dly = dqm_q[DQM_LAT-1];

  // tap chosen by CAS latency; code 0 uses the first stage
  always_comb begin
    on_bus = pipe_q[0];
    for (int i = 1; i < MAX_CL; i++)
      if (int'(cas_lat_i) == i + 1) on_bus = pipe_q[i];
  end

  assign live_lanes_o = {LANES{on_bus}} & ~dqm_dly;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[8*g +: 8] = dq_in_i[8*g +: 8] & {8{~dqm_dly[g]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_be_o    <= '0;
    end else begin
      rd_valid_o <= on_bus;
      rd_data_o  <= on_bus ? masked : '0;
      rd_be_o    <= on_bus ? ~dqm_dly : '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_masked_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_o && !rd_be_o[g]) |-> (rd_data_o[8*g +: 8] == 8'h00));
  end

endmodule

// File: rtl/sdram_wr_drive.sv
module sdram_wr_drive #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              beat_i,
  input  logic [LANES-1:0]  dqm_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] dq_out_o,
  output logic [LANES-1:0]  dq_oe_o
);

  assign dq_oe_o = {LANES{beat_i}} & ~dqm_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_out_o[8*g +: 8] = wr_data_i[8*g +: 8] & {8{dq_oe_o[g]}};
  end

endmodule

// File: rtl/sdram_dq_path.sv
module sdram_dq_path
  import sdram_dq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MAX_CL  = 3,
  parameter int unsigned CL_W    = 2,
  parameter int unsigned DQM_LAT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CL_W-1:0]       cas_lat_i,
  input  logic [2:0]            burst_code_i,
  input  logic                  wr_single_i,
  input  logic                  rd_cmd_i,
  input  logic                  wr_cmd_i,
  input  logic                  stop_cmd_i,
  input  logic                  pre_cmd_i,
  input  logic [DATA_W/8-1:0]   dqm_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [DATA_W-1:0]     dq_in_i,
  output logic [DATA_W-1:0]     dq_out_o,
  output logic [DATA_W/8-1:0]   dq_oe_o,
  output logic                  rd_valid_o,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [DATA_W/8-1:0]   rd_be_o
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [BEAT_W-1:0] rd_len, wr_len;
  logic              page, rd_term, wr_term, rd_beat, wr_beat;
  logic [LANES-1:0]  live_lanes;

  assign page    = (burst_code_i == BL_PAGE);
  assign rd_len  = bl_beats(burst_code_i);
  assign wr_len  = wr_single_i ? BEAT_W'(1) : rd_len;
  assign rd_term = stop_cmd_i || pre_cmd_i || wr_cmd_i;
  assign wr_term = stop_cmd_i || pre_cmd_i || rd_cmd_i;

  sdram_burst_ctr #(.CNT_W(BEAT_W)) u_rd_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rd_cmd_i),
    .term_i  (rd_term),
    .cont_i  (page),
    .len_i   (rd_len),
    .beat_o  (rd_beat)
  );

  sdram_burst_ctr #(.CNT_W(BEAT_W)) u_wr_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_cmd_i),
    .term_i  (wr_term),
    .cont_i  (page && !wr_single_i),
    .len_i   (wr_len),
    .beat_o  (wr_beat)
  );

  sdram_rd_align #(
    .DATA_W (DATA_W), .LANES (LANES), .MAX_CL (MAX_CL),
    .CL_W (CL_W), .DQM_LAT (DQM_LAT)
  ) u_rd_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_i       (rd_beat),
    .cas_lat_i    (cas_lat_i),
    .dqm_i        (dqm_i),
    .dq_in_i      (dq_in_i),
    .live_lanes_o (live_lanes),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .rd_be_o      (rd_be_o)
  );

  sdram_wr_drive #(.DATA_W (DATA_W), .LANES (LANES)) u_wr_drive (
    .beat_i    (wr_beat),
    .dqm_i     (dqm_i),
    .wr_data_i (wr_data_i),
    .dq_out_o  (dq_out_o),
    .dq_oe_o   (dq_oe_o)
  );

  // R1: latency at CL=2, read issued three cycles back and not cancelled
  p_rd_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_i == CL_W'(2) && $past(cas_lat_i, 3) == CL_W'(2) &&
     $past(rd_cmd_i && !rd_term, 3)) |-> rd_valid_o);

  // R5: read mask acts on the beat reported three cycles later
  p_rd_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_be_o == ~$past(dqm_i, 3)));

  // R6: at CL=3 the beat cancelled by a precharge never reports
  p_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_i == CL_W'(3) && $past(cas_lat_i, 4) == CL_W'(3) &&
     $past(pre_cmd_i, 4)) |-> !rd_valid_o);

  // R8: single-beat write mode leaves the bus one cycle after the command
  p_single_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_single_i && $past(wr_single_i) && $past(wr_cmd_i) && !wr_cmd_i)
      |-> (dq_oe_o == '0));

  // R10: drivers never overlap unmasked returning read data
  p_no_contention_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o & live_lanes) == '0);

endmodule

// File: tb/tb_sdram_dq_path.sv
`timescale 1ns/100ps
module tb_sdram_dq_path;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cas_lat_i = 2'd2;
  logic [2:0]  burst_code_i = 3'd0;
  logic        wr_single_i = 1'b0;
  logic        rd_cmd_i = 1'b0, wr_cmd_i = 1'b0, stop_cmd_i = 1'b0, pre_cmd_i = 1'b0;
  logic [3:0]  dqm_i = 4'h0;
  logic [31:0] wr_data_i = '0, dq_in_i = '0;
  logic [31:0] dq_out_o, rd_data_o;
  logic [3:0]  dq_oe_o, rd_be_o;
  logic        rd_valid_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  sdram_dq_path dut (
    .clk_i, .rst_ni, .cas_lat_i, .burst_code_i, .wr_single_i,
    .rd_cmd_i, .wr_cmd_i, .stop_cmd_i, .pre_cmd_i, .dqm_i,
    .wr_data_i, .dq_in_i, .dq_out_o, .dq_oe_o, .rd_valid_o,
    .rd_data_o, .rd_be_o
  );

  always #2.5 clk_i = ~clk_i;

  localparam int N = 40;
  logic        v_r [N];
  logic [31:0] d_r [N];
  logic [3:0]  be_r [N];
  logic [3:0]  oe_r [N];
  logic [31:0] do_r [N];
  int k;

  function automatic logic [31:0] pat(int c);
    return 32'h1122_3344 ^ (32'(c) * 32'h0103_0507);
  endfunction
  function automatic logic [31:0] wpat(int c);
    return 32'hA5C3_0F00 + 32'(c) * 32'h0101_0101;
  endfunction
  function automatic logic [31:0] expand(logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // entered at a falling edge; samples after the drive, returns at the next falling edge
  task automatic step(logic rd, logic wr, logic stp, logic pre, logic [3:0] m);
    rd_cmd_i = rd; wr_cmd_i = wr; stop_cmd_i = stp; pre_cmd_i = pre; dqm_i = m;
    wr_data_i = wpat(k);
    dq_in_i = pat(k);
    #1;
    v_r[k] = rd_valid_o; d_r[k] = rd_data_o; be_r[k] = rd_be_o;
    oe_r[k] = dq_oe_o; do_r[k] = dq_out_o;
    k++;
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      k = 0;
      step(0, 0, 0, 0, 4'h0);
    end
  endtask

  task automatic run_read(string req, int cl, int code, bit single, int nexp,
                          int term_at, bit term_pre, int mcyc, logic [3:0] mval);
    int drained;
    cas_lat_i = 2'(cl); burst_code_i = 3'(code); wr_single_i = single;
    idle(6);
    k = 0;
    for (int c = 0; c < N; c++)
      step(c == 0, 0, (c == term_at) && !term_pre, (c == term_at) && term_pre,
           (c == mcyc) ? mval : 4'h0);
    drained = 0;
    for (int c = 0; c < N; c++) begin
      logic       ev;
      logic [3:0] eb;
      ev = (c >= cl + 1) && (c <= cl + nexp);
      eb = ev ? ((c - 3 == mcyc) ? ~mval : 4'hF) : 4'h0;
      chk(req, $sformatf("rd_valid cycle %0d", c), 32'(v_r[c]), 32'(ev));
      chk(req, $sformatf("rd_be cycle %0d", c), 32'(be_r[c]), 32'(eb));
      if (ev) chk(req, $sformatf("rd_data cycle %0d", c), d_r[c], pat(c - 1) & expand(eb));
      chk("R10", $sformatf("dq_oe during read cycle %0d", c), 32'(oe_r[c]), 32'h0);
      if (term_at >= 0 && c >= term_at + 2 && v_r[c]) drained++;
    end
    if (term_at >= 0) chk("R6", "beats drained after termination", 32'(drained), 32'(cl - 1));
  endtask

  task automatic run_write(string req, int code, bit single, int nexp,
                           int term_at, bit term_pre, int mcyc, logic [3:0] mval);
    burst_code_i = 3'(code); wr_single_i = single;
    idle(6);
    k = 0;
    for (int c = 0; c < N; c++)
      step(0, c == 0, (c == term_at) && !term_pre, (c == term_at) && term_pre,
           (c == mcyc) ? mval : 4'h0);
    for (int c = 0; c < N; c++) begin
      logic [3:0] eo;
      eo = (c < nexp) ? ((c == mcyc) ? ~mval : 4'hF) : 4'h0;
      chk(req, $sformatf("dq_oe cycle %0d", c), 32'(oe_r[c]), 32'(eo));
      if (c < nexp) chk("R3", $sformatf("dq_out cycle %0d", c), do_r[c], wpat(c) & expand(eo));
      chk(req, $sformatf("no read valid cycle %0d", c), 32'(v_r[c]), 32'h0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    // R9: outputs at rest during reset
    chk("R9", "rd_valid in reset", 32'(rd_valid_o), 32'h0);
    chk("R9", "rd_be in reset", 32'(rd_be_o), 32'h0);
    chk("R9", "rd_data in reset", rd_data_o, 32'h0);
    chk("R9", "dq_oe in reset", 32'(dq_oe_o), 32'h0);
    rst_ni = 1'b1;
    idle(3);
    chk("R9", "rd_valid after reset", 32'(rd_valid_o), 32'h0);
    chk("R9", "dq_oe after reset", 32'(dq_oe_o), 32'h0);

    run_read("R1", 2, 2, 0, 4, -1, 0, -1, 4'h0);   // CL2, four beats
    run_read("R1", 1, 1, 0, 2, -1, 0, -1, 4'h0);   // CL1, two beats
    run_read("R1", 3, 0, 0, 1, -1, 0, -1, 4'h0);   // CL3, one beat
    run_read("R2", 2, 3, 0, 8, -1, 0, -1, 4'h0);   // eight beats
    run_read("R2", 2, 5, 0, 1, -1, 0, -1, 4'h0);   // reserved code gives one
    run_read("R5", 3, 2, 0, 4, -1, 0, 2, 4'b0101); // read mask two cycles late
    run_read("R6", 3, 3, 0, 3, 3, 1, -1, 4'h0);    // precharge at CL3
    run_read("R6", 2, 3, 0, 3, 3, 1, -1, 4'h0);    // precharge at CL2
    run_read("R6", 1, 3, 0, 3, 3, 1, -1, 4'h0);    // precharge at CL1
    run_read("R2", 2, 7, 0, 10, 10, 0, -1, 4'h0);  // page burst ended by stop
    run_read("R8", 2, 2, 1, 4, -1, 0, -1, 4'h0);   // reads keep length in single mode

    run_write("R4", 2, 0, 4, -1, 0, 1, 4'b0011);   // write mask same cycle
    run_write("R3", 3, 0, 8, -1, 0, -1, 4'h0);
    run_write("R7", 3, 0, 3, 3, 0, -1, 4'h0);      // stop ends write
    run_write("R7", 3, 0, 2, 2, 1, -1, 4'h0);      // precharge ends write
    run_write("R8", 2, 1, 1, -1, 0, -1, 4'h0);     // single-beat write
    run_write("R8", 7, 1, 1, -1, 0, -1, 4'h0);     // single even for page code

    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule